// File: doc/BRIEF.md
# Gated Clock Selector and Fanout

This block chooses between a primary system clock and a slower scan or test clock, gates the chosen clock with an active-low enable, and fans the result out to a set of identical true and complement output pairs. The default build has five pairs. A select input picks the source. An idle-low select routes the primary clock.

The enable is never applied to the clock directly. A flop clocked on the falling edge of the chosen clock samples it, and the flop's output qualifies the clock. The gate therefore opens or closes only while the chosen clock is low. A high phase is never cut short and never starts late. An asynchronous reset clears the flop, so all true outputs stay low until the first falling edge that sees the enable asserted. Electrical levels, skew and jitter are not modelled.

Top module: `clk_sel_fanout`

## Requirements
- R1: With sel_i = 0 the primary clock is the source. With en_ni = 0 as well, every true output is high during the primary clock's high phase and low during its low phase, and the scan clock has no effect.
- R2: With sel_i = 1 the scan clock is the source. With en_ni = 0, every true output follows the scan clock, and the primary clock has no effect.
- R3: en_ni is active low. With en_ni = 1 sampled, every true output stays low whatever the clocks do.
- R4: A change on en_ni takes effect only at the next falling edge of the selected clock. An enable asserted during a high phase does not raise the outputs in that phase. A disable during a high phase does not lower them in that phase.
- R5: Every high pulse on an output lasts exactly one full high phase of the selected clock, even while en_ni changes at arbitrary times. This holds as long as sel_i changes only while both clocks are low.
- R6: All NUM_PAIRS true outputs carry the same value at all times.
- R7: Each complement output clk_n_o[i] is always the inverse of clk_o[i].
- R8: While rst_ni = 0 all true outputs are low. After reset is released they stay low until the first falling edge of the selected clock that samples en_ni = 0, and they rise at the next rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset of the enable flop |
| pri_clk_i | input | 1 | Primary system clock |
| scan_clk_i | input | 1 | Scan or test clock |
| sel_i | input | 1 | Source select: 0 primary, 1 scan |
| en_ni | input | 1 | Active-low output enable, sampled on the falling edge of the selected clock |
| clk_o | output | NUM_PAIRS | Gated true clock outputs |
| clk_n_o | output | NUM_PAIRS | Gated complement clock outputs |

## Verification
The hardest case to reach from the ports is an enable change that lands inside a high phase of the selected clock. Only such a change could truncate a pulse or create a runt. Directed steps raise and drop en_ni a few nanoseconds into a high phase of each source in turn. They check that the current phase is left intact and that the following phase obeys the new setting. A randomised phase then toggles en_ni at offsets that never coincide with a clock edge, and switches the source only while both clocks are low. A monitor measures every output high pulse against the half period of the source that was selected when the pulse began.

// File: rtl/clk_fan_pkg.sv
`timescale 1ns/1ps
package clk_fan_pkg;
  parameter int unsigned DEF_PAIRS = 5;

  typedef enum logic {
    SRC_PRI  = 1'b0,
    SRC_SCAN = 1'b1
  } clk_src_e;
endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux
  import clk_fan_pkg::*;
(
  input  logic     pri_clk_i,
  input  logic     scan_clk_i,
  input  clk_src_e src_i,
  output logic     clk_o
);
  always_comb begin
    unique case (src_i)
      SRC_SCAN: clk_o = scan_clk_i;
      default:  clk_o = pri_clk_i;
    endcase
  end
endmodule

// File: rtl/clk_en_sync.sv
`timescale 1ns/1ps
module clk_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic gclk_o
);
  logic en_q;

  // falling-edge capture: gate only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ~en_ni;
  end

  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clk_fanout.sv
`timescale 1ns/1ps
module clk_fanout #(
  parameter int unsigned NUM_PAIRS = clk_fan_pkg::DEF_PAIRS
) (
  input  logic                 clk_i,
  output logic [NUM_PAIRS-1:0] clk_o,
  output logic [NUM_PAIRS-1:0] clk_n_o
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign clk_o[g]   = clk_i;
    assign clk_n_o[g] = ~clk_i;
  end
endmodule

// File: rtl/clk_sel_fanout.sv
`timescale 1ns/1ps
module clk_sel_fanout
  import clk_fan_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = DEF_PAIRS
) (
  input  logic                 rst_ni,
  input  logic                 pri_clk_i,
  input  logic                 scan_clk_i,
  input  logic                 sel_i,
  input  logic                 en_ni,
  output logic [NUM_PAIRS-1:0] clk_o,
  output logic [NUM_PAIRS-1:0] clk_n_o
);
  clk_src_e src;
  logic     sel_clk;
  logic     gated_clk;

  assign src = sel_i ? SRC_SCAN : SRC_PRI;

  clk_src_mux u_mux (
    .pri_clk_i  (pri_clk_i),
    .scan_clk_i (scan_clk_i),
    .src_i      (src),
    .clk_o      (sel_clk)
  );

  clk_en_sync u_gate (
    .clk_i  (sel_clk),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .gclk_o (gated_clk)
  );

  clk_fanout #(.NUM_PAIRS(NUM_PAIRS)) u_fan (
    .clk_i   (gated_clk),
    .clk_o   (clk_o),
    .clk_n_o (clk_n_o)
  );
endmodule

// File: rtl/clk_sel_fanout_chk.sv
`timescale 1ns/1ps
module clk_sel_fanout_chk #(
  parameter int unsigned NUM_PAIRS = clk_fan_pkg::DEF_PAIRS
) (
  input logic                 rst_ni,
  input logic                 pri_clk_i,
  input logic                 scan_clk_i,
  input logic                 sel_i,
  input logic                 en_ni,
  input logic [NUM_PAIRS-1:0] clk_o,
  input logic [NUM_PAIRS-1:0] clk_n_o
);
  AST_RST_LOW: assert property (@(posedge pri_clk_i)
    !rst_ni |-> clk_o == '0); // R8

  AST_FAN_EQUAL: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    ($countones(clk_o) == 0) || ($countones(clk_o) == NUM_PAIRS)); // R6

  AST_PAIR_INV: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    (clk_o ^ clk_n_o) == {NUM_PAIRS{1'b1}}); // R7

  AST_PRI_LOW_PHASE: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    !sel_i |-> clk_o == '0); // R1

  AST_SCAN_LOW_PHASE: assert property (@(posedge scan_clk_i) disable iff (!rst_ni)
    sel_i |-> clk_o == '0); // R2

  AST_EN_LATENCY: assert property (@(negedge pri_clk_i) disable iff (!rst_ni)
    (!sel_i && $past(!sel_i) && $past(rst_ni)) |-> clk_o[0] == $past(!en_ni)); // R4
endmodule

bind clk_sel_fanout clk_sel_fanout_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .rst_ni     (rst_ni),
  .pri_clk_i  (pri_clk_i),
  .scan_clk_i (scan_clk_i),
  .sel_i      (sel_i),
  .en_ni      (en_ni),
  .clk_o      (clk_o),
  .clk_n_o    (clk_n_o)
);

// File: tb/tb_clk_sel_fanout.sv
`timescale 1ns/1ps
module tb_clk_sel_fanout;
  localparam int unsigned N = 5;

  logic         rst_ni, pri_clk, scan_clk, sel, en_n;
  logic [N-1:0] clk_o, clk_n_o;
  int           checks = 0, errs = 0;
  bit           mon_on = 0;
  time          rise_t;
  logic         rise_sel;

  clk_sel_fanout #(.NUM_PAIRS(N)) dut (
    .rst_ni(rst_ni), .pri_clk_i(pri_clk), .scan_clk_i(scan_clk),
    .sel_i(sel), .en_ni(en_n), .clk_o(clk_o), .clk_n_o(clk_n_o)
  );

  // primary: 50 MHz, high [10,20) mod 20; scan: period 60, high [30,60) mod 60
  initial begin pri_clk = 0; forever #10 pri_clk = ~pri_clk; end
  initial begin scan_clk = 0; forever #30 scan_clk = ~scan_clk; end

  task automatic chk_out(input string tag, input logic exp_hi);
    logic [N-1:0] exp;
    exp = exp_hi ? '1 : '0;
    checks++;
    if (clk_o !== exp || clk_n_o !== ~exp) begin
      errs++;
      $display("FAIL %s t=%0t clk_o=%b clk_n_o=%b expected %b/%b",
               tag, $time, clk_o, clk_n_o, exp, ~exp);
    end
  endtask

  // R5: each high pulse is exactly one high phase of the source selected at its rise
  always @(posedge clk_o[0]) begin rise_t = $time; rise_sel = sel; end
  always @(negedge clk_o[0]) begin
    if (mon_on && rst_ni) begin
      time w, exp_w;
      w = $time - rise_t;
      exp_w = rise_sel ? 30 : 10;
      checks++;
      if (w != exp_w) begin
        errs++;
        $display("FAIL R5 pulse width %0t expected %0t at t=%0t", w, exp_w, $time);
      end
    end
  end

  // bits {sel, en_n}
  localparam logic [1:0] VEC [8] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                     2'b00, 2'b10, 2'b01, 2'b00};

  // R4: enable step inside a high phase of the chosen source
  task automatic en_step(input logic s);
    int hp;
    hp = s ? 30 : 10;
    @(negedge scan_clk); #2;
    sel = s; en_n = 1;
    @(negedge scan_clk); @(negedge scan_clk);
    if (s) @(negedge scan_clk); else @(negedge pri_clk);
    #(hp + 2);
    chk_out(s ? "R2/R3 disabled" : "R1/R3 disabled", 1'b0);
    en_n = 0;
    #3 chk_out("R4 no late start", 1'b0);
    if (s) @(negedge scan_clk); else @(negedge pri_clk);
    #(hp + 2) chk_out("R4 enabled next phase", 1'b1);
    en_n = 1;
    #5 chk_out("R4 high phase not truncated", 1'b1);
    if (s) @(negedge scan_clk); else @(negedge pri_clk);
    #(hp + 2) chk_out("R4 disabled next phase", 1'b0);
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired at t=%0t", $time);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_ni = 0; sel = 0; en_n = 0;
    // R8: held low in reset during a primary high phase
    #35 chk_out("R8 in reset", 1'b0);
    #7 rst_ni = 1;                        // t=42, primary low
    #13 chk_out("R8 before first fall", 1'b0); // t=55, primary high
    #20 chk_out("R8 after first fall", 1'b1);  // t=75

    // table walk: apply while both clocks low
    foreach (VEC[i]) begin
      @(negedge scan_clk); #2;
      sel = VEC[i][1]; en_n = VEC[i][0];
      @(negedge scan_clk);
      #15 chk_out(sel ? "R2 primary high ignored" : "R1/R3 primary high",
                  !sel && !en_n);
      #30 chk_out(sel ? "R2/R3 scan high" : "R1 scan high ignored",
                  sel && !en_n);
    end

    en_step(1'b0);
    en_step(1'b1);

    // R5/R6: random enable activity, source switched only while both clocks low
    mon_on = 1;
    repeat (25) begin
      @(negedge scan_clk); #2;
      sel = 1'($urandom);
      repeat (4) begin
        #((($urandom % 2) * 10) + 3);
        en_n = 1'($urandom);
      end
      if ($time % 10 != 0) chk_out("R6/R7 fanout", clk_o[0]);
    end
    mon_on = 0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule